// File: doc/BRIEF.md
# Floating-Point Operand Screen and Trap Reporter

This block sits beside a double-precision arithmetic pipeline and handles the two points where the pipeline has to decide whether to trap. Before an operation, an operand can be presented for screening. The block looks at the exponent and fraction fields and decides whether the operand is allowed. There are three screening variants: normal, compare, and software-completion. After an operation, the pipeline commits the status flags that the operation raised. The block then updates a sticky status register, applies the instruction's ignore mask and, for software-completion instructions, the per-flag enable mask. When a trap is needed, it issues a request that carries a cause summary and a one-hot mask naming the destination register.

The flags of one instruction can arrive through a flag strobe over one or more cycles. They are held as pending until the commit, and the commit clears them. Software reads and writes the sticky status register through a simple CSR port. A software write overrides any flag accumulation in the same cycle. The arithmetic itself is not part of this block.

Top module: `fpx_trap_unit`

## Requirements
- R1: While reset is asserted and directly after it, `trap_valid` is 0, `trap_cause` and `trap_regmask` are all zero, and `csr_rdata` reads 0.
- R2: Normal screening (`chk_mode` = 2'b00) traps on a denormal, meaning exponent bits 62:52 all zero with a nonzero fraction in bits 51:0. The trap has cause bit 1 (invalid) set. Normal screening also traps on an all-ones exponent and then additionally sets sticky bit 0 (invalid). Zeros and normal numbers pass, and a denormal leaves the sticky register unchanged. Mode 2'b11 screens nothing.
- R3: Compare screening (`chk_mode` = 2'b01) passes infinities, meaning an all-ones exponent with a zero fraction. It traps on a NaN (all-ones exponent, nonzero fraction) and sets sticky bit 0. It traps on a denormal without touching the sticky register.
- R4: Software-completion screening (`chk_mode` = 2'b10) traps on a denormal of either sign, with cause bits 1 and 0 (software completion) set. It does not trap when `flush_denorm` is 1, and it never traps on a zero, an infinity or a NaN. This variant never updates the sticky register.
- R5: A commit without software completion ORs every committed flag into the sticky register. It traps when any flag outside `cmt_ignore` is set, and the cause carries exactly those flags. Flag bit i maps to cause bit i+1. The flag order is 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 integer overflow.
- R6: A commit with software completion (`cmt_swc` = 1) ORs only the flags outside `cmt_ignore` into the sticky register. It traps only when one of those flags is also set in `trap_enable`. The cause then carries those flags plus cause bit 0.
- R7: A commit trap drives `trap_regmask` with the single bit `cmt_dest` set. An operand-screen trap drives an all-zero mask. A commit trap takes precedence over a screen trap in the same cycle.
- R8: A trap is reported exactly one cycle after the strobe that caused it, as a one-cycle pulse of `trap_valid`. When `trap_valid` is 0, the cause and the mask are zero.
- R9: `flag_in` values strobed by `flag_valid` accumulate as pending flags. A commit uses the pending flags together with any flags strobed in the same cycle, and then clears them, so no flag carries over to the next instruction.
- R10: A CSR write loads `csr_wdata` into the sticky register and overrides any accumulation in the same cycle. `csr_rdata` shows the register.
- R11: Apart from a CSR write, sticky bits are only ever set and never cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | Operand screen strobe |
| chk_mode | input | 2 | Screen variant: 00 normal, 01 compare, 10 software completion, 11 none |
| chk_operand | input | 64 | Double-format operand to screen |
| flush_denorm | input | 1 | Inputs flushed to zero; suppresses the software-completion denormal trap |
| flag_valid | input | 1 | Raised-flag strobe |
| flag_in | input | 6 | Raised flags |
| cmt_valid | input | 1 | Status commit strobe |
| cmt_swc | input | 1 | Committing instruction uses software completion |
| cmt_ignore | input | 6 | Flags the instruction does not trap on |
| cmt_dest | input | 5 | Destination register number |
| trap_enable | input | 6 | Per-flag trap enable for software completion |
| csr_we | input | 1 | Sticky register write strobe |
| csr_wdata | input | 6 | Sticky register write data |
| csr_rdata | output | 6 | Sticky status register |
| trap_valid | output | 1 | Trap request pulse |
| trap_cause | output | 7 | Cause: bit 0 software completion, bits 6:1 flags |
| trap_regmask | output | 32 | One-hot destination register mask |

## Verification
Several properties are checked on every cycle. Every trap pulse must follow a strobe, and its cause and mask must be zero when no trap is present. A commit trap must carry a one-hot mask. The sticky register must only grow unless it is written. A CSR write must land as written. A flushed software-completion screen must stay silent, and an all-ones exponent under normal screening must set the sticky invalid bit. The other behaviours can only be shown by the bench scenarios, because they depend on particular operand encodings and flag and mask combinations. These are the difference between infinities and NaNs across the three variants, the sign of a denormal, the interaction of ignore and enable masks, the carrying and clearing of pending flags, and the same-cycle conflicts.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_N  = 6;
  localparam int CAUSE_W = FLAG_N + 1;

  localparam int FL_INV = 0;
  localparam int FL_DZE = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;
  localparam int FL_INE = 4;
  localparam int FL_IOV = 5;

  localparam int CAUSE_SWC = 0;

  typedef enum logic [1:0] {
    SCR_NORMAL = 2'b00,
    SCR_CMP    = 2'b01,
    SCR_SWC    = 2'b10,
    SCR_OFF    = 2'b11
  } scr_mode_e;

  typedef struct packed {
    logic zero;
    logic denorm;
    logic inf;
    logic nan;
  } op_class_t;
endpackage

// File: rtl/fpx_operand_screen.sv
module fpx_operand_screen
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int OP_W  = EXP_W + FRAC_W + 1
) (
  input  logic            valid,
  input  logic [1:0]      mode,
  input  logic [OP_W-1:0] operand,
  input  logic            flush,
  output logic            trap,
  output logic            sticky_inv,
  output logic            swc
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              sign_unused;
  op_class_t         cls;
  scr_mode_e         m;

  assign expo        = operand[OP_W-2 -: EXP_W];
  assign frac        = operand[FRAC_W-1:0];
  assign sign_unused = operand[OP_W-1];
  assign m           = scr_mode_e'(mode);

  always_comb begin
    cls.zero   = (expo == '0) && (frac == '0);
    cls.denorm = (expo == '0) && (frac != '0);
    cls.inf    = (expo == '1) && (frac == '0);
    cls.nan    = (expo == '1) && (frac != '0);
  end

  always_comb begin
    trap       = 1'b0;
    sticky_inv = 1'b0;
    swc        = 1'b0;
    if (valid) begin
      unique case (m)
        SCR_NORMAL: begin
          trap       = cls.denorm | cls.inf | cls.nan;
          sticky_inv = cls.inf | cls.nan;
        end
        SCR_CMP: begin
          trap       = cls.denorm | cls.nan;
          sticky_inv = cls.nan;
        end
        SCR_SWC: begin
          trap = cls.denorm & ~flush;
          swc  = trap;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpx_commit_eval.sv
module fpx_commit_eval
  import fpx_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              valid,
  input  logic              swc_mode,
  input  logic [FLAG_N-1:0] flags,
  input  logic [FLAG_N-1:0] ignore,
  input  logic [FLAG_N-1:0] enable,
  input  logic [IDX_W-1:0]  dest,
  output logic              trap,
  output logic [FLAG_N-1:0] cause_flags,
  output logic [FLAG_N-1:0] sticky_add,
  output logic [NREGS-1:0]  regmask
);
  logic [FLAG_N-1:0] kept;

  always_comb begin
    kept        = flags & ~ignore;
    sticky_add  = '0;
    cause_flags = '0;
    if (valid) begin
      if (swc_mode) begin
        sticky_add  = kept;
        cause_flags = kept & enable;
      end else begin
        sticky_add  = flags;
        cause_flags = kept;
      end
    end
    trap = |cause_flags;
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_dec
    assign regmask[g] = trap && (dest == IDX_W'(g));
  end
endmodule

// File: rtl/fpx_sticky_csr.sv
module fpx_sticky_csr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    en = we | (|set_bits);
    d  = we ? wdata : (q | set_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int NREGS  = 32,
  localparam int OP_W  = EXP_W + FRAC_W + 1,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_valid,
  input  logic [1:0]         chk_mode,
  input  logic [OP_W-1:0]    chk_operand,
  input  logic               flush_denorm,
  input  logic               flag_valid,
  input  logic [FLAG_N-1:0]  flag_in,
  input  logic               cmt_valid,
  input  logic               cmt_swc,
  input  logic [FLAG_N-1:0]  cmt_ignore,
  input  logic [IDX_W-1:0]   cmt_dest,
  input  logic [FLAG_N-1:0]  trap_enable,
  input  logic               csr_we,
  input  logic [FLAG_N-1:0]  csr_wdata,
  output logic [FLAG_N-1:0]  csr_rdata,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [NREGS-1:0]   trap_regmask
);
  logic               scr_trap, scr_inv, scr_swc;
  logic               cm_trap;
  logic [FLAG_N-1:0]  cm_cause, cm_add;
  logic [NREGS-1:0]   cm_mask;
  logic [FLAG_N-1:0]  pend_q, pend_d, cmt_flags, sticky_set;
  logic               tv_d;
  logic [CAUSE_W-1:0] tc_d;
  logic [NREGS-1:0]   tm_d;

  fpx_operand_screen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_screen (
    .valid(chk_valid), .mode(chk_mode), .operand(chk_operand),
    .flush(flush_denorm), .trap(scr_trap), .sticky_inv(scr_inv), .swc(scr_swc)
  );

  always_comb begin
    cmt_flags = pend_q | (flag_valid ? flag_in : '0);
    pend_d    = cmt_valid ? '0 : cmt_flags;
  end

  fpx_commit_eval #(.NREGS(NREGS)) u_commit (
    .valid(cmt_valid), .swc_mode(cmt_swc), .flags(cmt_flags),
    .ignore(cmt_ignore), .enable(trap_enable), .dest(cmt_dest),
    .trap(cm_trap), .cause_flags(cm_cause), .sticky_add(cm_add), .regmask(cm_mask)
  );

  always_comb begin
    sticky_set         = cm_add;
    sticky_set[FL_INV] = cm_add[FL_INV] | scr_inv;
  end

  fpx_sticky_csr #(.W(FLAG_N)) u_sticky (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata),
    .set_bits(sticky_set), .q(csr_rdata)
  );

  always_comb begin
    tv_d = cm_trap | scr_trap;
    tc_d = '0;
    tm_d = '0;
    if (cm_trap) begin
      tc_d[CAUSE_W-1:1]  = cm_cause;
      tc_d[CAUSE_SWC]    = cmt_swc;
      tm_d               = cm_mask;
    end else if (scr_trap) begin
      tc_d[1 + FL_INV]   = 1'b1;
      tc_d[CAUSE_SWC]    = scr_swc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= '0;
      trap_valid   <= 1'b0;
      trap_cause   <= '0;
      trap_regmask <= '0;
    end else begin
      pend_q       <= pend_d;
      trap_valid   <= tv_d;
      trap_cause   <= tc_d;
      trap_regmask <= tm_d;
    end
  end
endmodule

// File: rtl/fpx_trap_unit_chk.sv
module fpx_trap_unit_chk #(
  parameter int OP_W    = 64,
  parameter int FLAG_N  = 6,
  parameter int CAUSE_W = 7,
  parameter int NREGS   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chk_valid,
  input logic [1:0]         chk_mode,
  input logic [OP_W-1:0]    chk_operand,
  input logic               flush_denorm,
  input logic               cmt_valid,
  input logic               csr_we,
  input logic [FLAG_N-1:0]  csr_wdata,
  input logic [FLAG_N-1:0]  csr_rdata,
  input logic               trap_valid,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [NREGS-1:0]   trap_regmask
);
  p_trap_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_cause[CAUSE_W-1:1] != '0) && $past(chk_valid || cmt_valid));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> (trap_cause == '0) && (trap_regmask == '0));

  p_onehot_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && $past(cmt_valid && !chk_valid)) |-> $countones(trap_regmask) == 1);

  p_screen_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && $past(chk_valid && !cmt_valid)) |-> trap_regmask == '0);

  p_csr_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csr_we) |-> csr_rdata == $past(csr_wdata));

  p_sticky_grow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_we) |-> (csr_rdata & $past(csr_rdata)) == $past(csr_rdata));

  p_flush_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chk_valid && chk_mode == 2'b10 && flush_denorm && !cmt_valid) |-> !trap_valid);

  p_nonfinite_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chk_valid && chk_mode == 2'b00 && chk_operand[OP_W-2 -: 11] == 11'h7ff && !csr_we)
      |-> csr_rdata[0]);
endmodule

bind fpx_trap_unit fpx_trap_unit_chk #(
  .OP_W(OP_W), .FLAG_N(fpx_pkg::FLAG_N), .CAUSE_W(fpx_pkg::CAUSE_W), .NREGS(NREGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_mode(chk_mode),
  .chk_operand(chk_operand), .flush_denorm(flush_denorm), .cmt_valid(cmt_valid),
  .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
  .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_regmask(trap_regmask)
);

// File: tb/sim_fpx_trap_unit.sv
module sim_fpx_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_valid, flush_denorm, flag_valid, cmt_valid, cmt_swc, csr_we;
  logic [1:0]  chk_mode;
  logic [63:0] chk_operand;
  logic [5:0]  flag_in, cmt_ignore, trap_enable, csr_wdata, csr_rdata;
  logic [4:0]  cmt_dest;
  logic        trap_valid;
  logic [6:0]  trap_cause;
  logic [31:0] trap_regmask;

  int     n_chk = 0, n_bad = 0;
  string  cur_req = "R1";
  logic [5:0]  m_sticky = 0, m_pend = 0;
  logic        m_tv = 0;
  logic [6:0]  m_tc = 0;
  logic [31:0] m_tm = 0;

  always #5 clk = ~clk;

  fpx_trap_unit u0 (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_mode(chk_mode),
    .chk_operand(chk_operand), .flush_denorm(flush_denorm), .flag_valid(flag_valid),
    .flag_in(flag_in), .cmt_valid(cmt_valid), .cmt_swc(cmt_swc),
    .cmt_ignore(cmt_ignore), .cmt_dest(cmt_dest), .trap_enable(trap_enable),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_regmask(trap_regmask)
  );

  task automatic check(string req, logic [70:0] act, logic [70:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on each rising edge from the sampled inputs
  always @(posedge clk) begin
    if (rst_n) begin
      automatic logic [10:0] e = chk_operand[62:52];
      automatic logic        fz = (chk_operand[51:0] == 0);
      automatic logic [5:0]  add = 0, fl, t;
      m_tv = 0; m_tc = 0; m_tm = 0;
      if (chk_valid) begin
        if (chk_mode == 2'b00 && ((e == 0 && !fz) || e == 11'h7ff)) begin
          m_tv = 1; m_tc = 7'b0000010;
          if (e == 11'h7ff) add[0] = 1;
        end else if (chk_mode == 2'b01 && ((e == 0 && !fz) || (e == 11'h7ff && !fz))) begin
          m_tv = 1; m_tc = 7'b0000010;
          if (e == 11'h7ff) add[0] = 1;
        end else if (chk_mode == 2'b10 && e == 0 && !fz && !flush_denorm) begin
          m_tv = 1; m_tc = 7'b0000011;
        end
      end
      fl = m_pend | (flag_valid ? flag_in : 6'd0);
      if (cmt_valid) begin
        if (cmt_swc) begin
          add = add | (fl & ~cmt_ignore);
          t = fl & ~cmt_ignore & trap_enable;
        end else begin
          add = add | fl;
          t = fl & ~cmt_ignore;
        end
        if (t != 0) begin
          m_tv = 1; m_tc = {t, cmt_swc}; m_tm = 32'd1 << cmt_dest;
        end
        m_pend = 0;
      end else m_pend = fl;
      if (csr_we) m_sticky = csr_wdata; else m_sticky = m_sticky | add;
      #2;
      check(cur_req, {trap_valid, trap_cause, trap_regmask, csr_rdata},
                     {m_tv, m_tc, m_tm, m_sticky});
    end
  end

  task automatic idle();
    chk_valid = 0; chk_mode = 0; chk_operand = 0; flag_valid = 0; flag_in = 0;
    cmt_valid = 0; cmt_swc = 0; cmt_ignore = 0; cmt_dest = 0; csr_we = 0; csr_wdata = 0;
  endtask

  task automatic screen(logic [1:0] md, logic [63:0] v);
    @(negedge clk); idle(); chk_valid = 1; chk_mode = md; chk_operand = v;
    @(negedge clk); idle();
  endtask

  task automatic commit(logic swc, logic [5:0] fl, logic [5:0] ign, logic [4:0] dst);
    @(negedge clk); idle(); cmt_valid = 1; cmt_swc = swc; flag_valid = 1; flag_in = fl;
    cmt_ignore = ign; cmt_dest = dst;
    @(negedge clk); idle();
  endtask

  task automatic wr_csr(logic [5:0] v);
    @(negedge clk); idle(); csr_we = 1; csr_wdata = v;
    @(negedge clk); idle();
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); flush_denorm = 0; trap_enable = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", {trap_valid, trap_cause, trap_regmask, csr_rdata}, 71'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {trap_valid, trap_cause, trap_regmask, csr_rdata}, 71'd0);

    cur_req = "R2";
    screen(2'b00, 64'h0000_0000_0000_0000);
    screen(2'b00, 64'h3FF0_0000_0000_0000);
    screen(2'b00, 64'h0000_0000_0000_0001);
    screen(2'b00, 64'h7FF0_0000_0000_0000);
    wr_csr(0);
    screen(2'b00, 64'hFFF8_0000_0000_0000);
    screen(2'b11, 64'h7FF8_0000_0000_0000);
    wr_csr(0);

    cur_req = "R3";
    screen(2'b01, 64'hFFF0_0000_0000_0000);
    screen(2'b01, 64'h7FF0_0000_0000_0001);
    wr_csr(0);
    screen(2'b01, 64'h800F_FFFF_FFFF_FFFF);

    cur_req = "R4";
    screen(2'b10, 64'h8000_0000_0000_0005);
    screen(2'b10, 64'h8000_0000_0000_0000);
    screen(2'b10, 64'h7FF8_0000_0000_0000);
    screen(2'b10, 64'h7FF0_0000_0000_0000);
    flush_denorm = 1;
    screen(2'b10, 64'h0000_0000_0000_0003);
    flush_denorm = 0;

    cur_req = "R5";
    commit(0, 6'b010100, 6'b010000, 5'd3);
    commit(0, 6'b100010, 6'b111111, 5'd4);
    wr_csr(0);

    cur_req = "R6";
    trap_enable = 6'b000001;
    commit(1, 6'b001001, 6'b001000, 5'd9);
    trap_enable = 6'b000000;
    commit(1, 6'b000110, 6'b000000, 5'd9);
    trap_enable = 6'b111111;
    commit(1, 6'b010000, 6'b010000, 5'd9);

    cur_req = "R7";
    commit(0, 6'b000001, 0, 5'd0);
    commit(0, 6'b000001, 0, 5'd31);
    @(negedge clk); idle(); cmt_valid = 1; flag_valid = 1; flag_in = 6'b000100; cmt_dest = 5'd17;
    chk_valid = 1; chk_mode = 2'b00; chk_operand = 64'h7FF0_0000_0000_0000;
    @(negedge clk); idle();

    cur_req = "R8";
    @(negedge clk); idle(); cmt_valid = 1; flag_valid = 1; flag_in = 6'b000010; cmt_dest = 5'd5;
    @(negedge clk); cmt_dest = 5'd6; flag_in = 6'b001000;
    @(negedge clk); idle();
    @(negedge clk);

    cur_req = "R9";
    wr_csr(0);
    @(negedge clk); idle(); flag_valid = 1; flag_in = 6'b000010;
    @(negedge clk); flag_in = 6'b100000;
    @(negedge clk); idle();
    commit(0, 6'b000000, 0, 5'd12);
    commit(0, 6'b000000, 0, 5'd12);

    cur_req = "R10";
    @(negedge clk); idle(); cmt_valid = 1; flag_valid = 1; flag_in = 6'b011000;
    csr_we = 1; csr_wdata = 6'b000001; cmt_dest = 5'd2;
    @(negedge clk); idle();
    wr_csr(6'b101010);

    cur_req = "R11";
    for (int i = 0; i < 6; i++) commit(1, 6'b000001 << i, 0, 5'(i));
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule